// File: doc/BRIEF.md
# Powerdown Entry/Exit Sequencer

This block steers a processor core into and out of its low-power state. Software writes a two-bit control word at a fixed data address: one bit asks for a long oscillator-settling wait on wake-up, the other stops the block from driving the crystal pin while the core sleeps. When the core reports that it has executed its idle instruction inside the powerdown handler, the sequencer lets the clock run for one more cycle, then gates the core clock and, if asked to, releases the crystal drive.

Two events wake the core. The first is a rising edge on the powerdown pin. The second is a reset request that is held long enough and then released. Both inputs pass through a synchronizer. After a wake event, a single down-counter times the startup phase before the core is released. A pin wake with the delay bit set adds the long settling wait to the base count. A reset wake always uses only the base count. A reset wake also marks that the core restarts from address zero, and it selects a boot when the memory-map input is low.

Top module: `pdn_sequencer`

## Requirements
- R1: After block reset the state code is RUN, and the clock enable, crystal drive, core run, restart-from-zero flag and boot select read 1, 1, 1, 0, 0.
- R2: A write to address 0x3FEF loads data bit 15 as the crystal-drive disable and bit 14 as the settling-delay enable. A write to any other address changes neither bit. Both bits reset to 0.
- R3: An idle strobe in RUN moves the block to DRAIN (code 3) for exactly one cycle with the clock enable still 1. The block then moves to POWERDOWN (code 1) with the clock enable and core run at 0. The RUN code is 0 and the STARTUP code is 2.
- R4: During POWERDOWN the crystal drive equals the inverse of the disable bit. In every other state it is 1.
- R5: A raw pin rise in POWERDOWN raises core run after BASE+3 clock edges, counted from the first edge that samples the pin high. BASE is 64 by default, and 4096 is added when the delay bit is 1.
- R6: A reset request held for at least 5 sampled cycles in POWERDOWN and then released raises core run after BASE+3 edges, counted from the first edge that samples it low, whatever the delay bit holds. It sets the restart flag to 1 and sets boot select to the inverse of the memory-map input.
- R7: A reset request held for fewer than 5 cycles leaves the block in POWERDOWN.
- R8: A qualified reset release during STARTUP discards the running count and restarts it at BASE.
- R9: Pin edges and reset releases in RUN have no effect. An idle strobe outside RUN has no effect. A pin that is already high when POWERDOWN starts does not wake the core.
- R10: A pin wake clears the restart flag and boot select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en_i | input | 1 | Data write strobe |
| wr_addr_i | input | ADDR_W | Data write address |
| wr_data_i | input | DATA_W | Data write value |
| idle_i | input | 1 | Core executed idle in the powerdown handler |
| pd_pin_i | input | 1 | Asynchronous powerdown wake pin |
| rst_req_i | input | 1 | Asynchronous active-high reset request |
| mmap_sel_i | input | 1 | Memory-map select (0 means boot) |
| clk_en_o | output | 1 | Core clock gate enable |
| xtal_drv_en_o | output | 1 | Crystal pin drive enable |
| core_run_o | output | 1 | Core released to execute |
| restart_zero_o | output | 1 | Last wake came from reset; restart at address zero |
| boot_sel_o | output | 1 | Boot requested on restart |
| state_o | output | 2 | State code: RUN 0, POWERDOWN 1, STARTUP 2, DRAIN 3 |

## Verification
The bench measures the wake latency to the exact edge for both exit paths and both delay settings. A design that applied the long wait on reset exit, or that miscounted a synchronizer stage, shows a different count. Reset pulses one cycle too short are checked against the 5-cycle limit, which catches a qualifier that accepts 4 cycles. A reset arriving in the middle of a long pin-driven startup must finish after only the base count; a design that kept the old count would finish thousands of cycles late. A pin left high across powerdown entry, and idle strobes during powerdown, must not wake the core or restart the sequence.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PDWN  = 2'd1,
    ST_START = 2'd2,
    ST_DRAIN = 2'd3
  } pd_state_e;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk) begin
      if (rst) sh_q <= '0;
      else     sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/pdn_rst_qual.sv
// Counts how long the synchronized reset request stays high and flags a
// release only after a hold of at least MIN_CYC cycles.
module pdn_rst_qual #(
  parameter int MIN_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic wake_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(MIN_CYC);

  logic [CW-1:0] held_q;
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (!lvl_i)                held_q <= '0;
      else if (held_q != HOLD_MAX) held_q <= held_q + 1'b1;
    end
  end

  assign wake_o = prev_q & ~lvl_i & (held_q == HOLD_MAX);

  a_r7_hold_sat: assert property (@(posedge clk) disable iff (rst)
    held_q <= HOLD_MAX);
  a_r7_clear_after_release: assert property (@(posedge clk) disable iff (rst)
    wake_o |=> (held_q == '0));
endmodule

// File: rtl/pdn_startup_cnt.sv
module pdn_startup_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
  import pdn_pkg::*;
#(
  parameter int                ADDR_W      = 14,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 14'h3FEF,
  parameter int                XDLY_BIT    = 14,
  parameter int                XDIS_BIT    = 15,
  parameter int                BASE_CYC    = 64,
  parameter int                XDLY_CYC    = 4096,
  parameter int                RST_MIN     = 5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              idle_i,
  input  logic              pd_pin_i,
  input  logic              rst_req_i,
  input  logic              mmap_sel_i,
  output logic              clk_en_o,
  output logic              xtal_drv_en_o,
  output logic              core_run_o,
  output logic              restart_zero_o,
  output logic              boot_sel_o,
  output logic [1:0]        state_o
);
  localparam int CNT_W = $clog2(BASE_CYC + XDLY_CYC + 1);
  localparam logic [CNT_W-1:0] LD_FAST = CNT_W'(BASE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SLOW = CNT_W'(BASE_CYC + XDLY_CYC - 1);

  // control register: only the two defined bits are stored
  logic xdly_q, xdis_q;
  logic unused_data;
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      xdly_q <= 1'b0;
      xdis_q <= 1'b0;
    end else if (wr_en_i && wr_addr_i == CTRL_ADDR) begin
      xdly_q <= wr_data_i[XDLY_BIT];
      xdis_q <= wr_data_i[XDIS_BIT];
    end
  end

  // synchronizers and wake detection
  logic [1:0] sync_s;
  logic       pin_s, rst_s, pin_prev_q, pin_rise, rst_wake;

  pdn_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst),
    .d_i ({rst_req_i, pd_pin_i}),
    .q_o (sync_s)
  );
  assign pin_s = sync_s[0];
  assign rst_s = sync_s[1];

  always_ff @(posedge clk) begin
    if (rst) pin_prev_q <= 1'b0;
    else     pin_prev_q <= pin_s;
  end
  assign pin_rise = pin_s & ~pin_prev_q;

  pdn_rst_qual #(.MIN_CYC(RST_MIN)) u_rst_qual (
    .clk (clk), .rst (rst), .lvl_i (rst_s), .wake_o (rst_wake)
  );

  // sequencing
  pd_state_e        state_q, nxt;
  logic             ld, by_rst, by_pin, cnt_done;
  logic [CNT_W-1:0] ld_val;

  always_comb begin
    nxt    = state_q;
    ld     = 1'b0;
    ld_val = LD_FAST;
    by_rst = 1'b0;
    by_pin = 1'b0;
    unique case (state_q)
      ST_RUN:   if (idle_i) nxt = ST_DRAIN;
      ST_DRAIN: nxt = ST_PDWN;
      ST_PDWN: begin
        if (rst_wake) begin
          nxt = ST_START; ld = 1'b1; by_rst = 1'b1;
        end else if (pin_rise) begin
          nxt = ST_START; ld = 1'b1; by_pin = 1'b1;
          ld_val = xdly_q ? LD_SLOW : LD_FAST;
        end
      end
      ST_START: begin
        if (rst_wake) begin
          ld = 1'b1; by_rst = 1'b1;
        end else if (cnt_done) begin
          nxt = ST_RUN;
        end
      end
      default: nxt = ST_RUN;
    endcase
  end

  pdn_startup_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk), .rst (rst),
    .load_i (ld), .load_val_i (ld_val),
    .run_i (state_q == ST_START),
    .done_o (cnt_done)
  );

  logic clk_en_q, xtal_q, run_q, restart_q, boot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      clk_en_q  <= 1'b1;
      xtal_q    <= 1'b1;
      run_q     <= 1'b1;
      restart_q <= 1'b0;
      boot_q    <= 1'b0;
    end else begin
      state_q   <= nxt;
      clk_en_q  <= (nxt != ST_PDWN);
      xtal_q    <= !((nxt == ST_PDWN) && xdis_q);
      run_q     <= (nxt == ST_RUN) || (nxt == ST_DRAIN);
      if (by_rst) begin
        restart_q <= 1'b1;
        boot_q    <= ~mmap_sel_i;
      end else if (by_pin) begin
        restart_q <= 1'b0;
        boot_q    <= 1'b0;
      end
    end
  end

  assign clk_en_o       = clk_en_q;
  assign xtal_drv_en_o  = xtal_q;
  assign core_run_o     = run_q;
  assign restart_zero_o = restart_q;
  assign boot_sel_o     = boot_q;
  assign state_o        = state_q;

  a_r3_drain_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DRAIN) |=> (state_q == ST_PDWN));
  a_r3_clock_gated: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDWN) |-> !clk_en_o);
  a_r4_xtal_follows_bit: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDWN) |-> (xtal_drv_en_o == !$past(xdis_q)));
  a_r5_held_in_startup: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START) |-> !core_run_o);
  a_r9_run_stays: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !idle_i) |=> (state_q == ST_RUN));
  a_r8_reset_in_startup: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && rst_wake) |=> (state_q == ST_START && restart_zero_o));
  a_r10_pin_clears: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PDWN && pin_rise && !rst_wake) |=> (!restart_zero_o && !boot_sel_o));
endmodule

// File: tb/pdn_sequencer_tb_top.sv
module pdn_sequencer_tb_top;
  localparam int BASE = 64;
  localparam int XD   = 4096;
  localparam int RMIN = 5;
  localparam logic [13:0] CADDR = 14'h3FEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic idle = 1'b0, pd_pin = 1'b0, rst_req = 1'b0, mmap = 1'b1;
  logic clk_en, xtal_en, core_run, restart_zero, boot_sel;
  logic [1:0] state;

  int vectors = 0;
  int fails   = 0;
  bit m_xdly = 1'b0, m_xdis = 1'b0;

  always #5 clk = ~clk;

  pdn_sequencer dut_i (
    .clk (clk), .rst (rst),
    .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .idle_i (idle), .pd_pin_i (pd_pin), .rst_req_i (rst_req), .mmap_sel_i (mmap),
    .clk_en_o (clk_en), .xtal_drv_en_o (xtal_en), .core_run_o (core_run),
    .restart_zero_o (restart_zero), .boot_sel_o (boot_sel), .state_o (state)
  );

  function automatic int exp_lat(bit by_pin, bit dly);
    return BASE + ((by_pin && dly) ? XD : 0) + 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_ctrl(logic [13:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == CADDR) begin
      m_xdly = d[14];
      m_xdis = d[15];
    end
  endtask

  task automatic enter_pd();
    @(negedge clk);
    idle = 1'b1;
    @(negedge clk);
    idle = 1'b0;
    chk("R3 drain state", state, 3);
    chk("R3 clk_en in drain", clk_en, 1);
    @(negedge clk);
    chk("R3 powerdown state", state, 1);
    chk("R3 clk_en gated", clk_en, 0);
    chk("R3 core_run low", core_run, 0);
    chk("R4 xtal drive", xtal_en, !m_xdis);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (n < 6000) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (core_run) break;
    end
  endtask

  task automatic pin_exit(string req);
    int n;
    @(negedge clk);
    pd_pin = 1'b1;
    measure(n);
    chk(req, n, exp_lat(1'b1, m_xdly));
    chk("R10 restart cleared", restart_zero, 0);
    chk("R10 boot cleared", boot_sel, 0);
    chk("R4 xtal on in run", xtal_en, 1);
    pd_pin = 1'b0;
  endtask

  task automatic rst_pulse(int len);
    @(negedge clk);
    rst_req = 1'b1;
    repeat (len) @(posedge clk);
    @(negedge clk);
    rst_req = 1'b0;
  endtask

  task automatic rst_exit(int len, bit mm);
    int n;
    mmap = mm;
    rst_pulse(len);
    measure(n);
    chk("R6 reset wake latency", n, exp_lat(1'b0, m_xdly));
    chk("R6 restart flag", restart_zero, 1);
    chk("R6 boot select", boot_sel, !mm);
  endtask

  task automatic short_rst();
    rst_pulse(RMIN - 1);
    repeat (20) @(negedge clk);
    chk("R7 short reset ignored", state, 1);
    chk("R7 core held", core_run, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 xtal", xtal_en, 1);
    chk("R1 core_run", core_run, 1);
    chk("R1 restart", restart_zero, 0);
    chk("R1 boot", boot_sel, 0);

    // R2 wrong address ignored
    write_ctrl(14'h3FEE, 16'hC000);
    m_xdly = 1'b0; m_xdis = 1'b0;
    enter_pd();
    chk("R2 stray write ignored", xtal_en, 1);
    pin_exit("R5 fast pin wake");

    // R2/R4/R5 slow start with drive off
    write_ctrl(CADDR, 16'hC000);
    enter_pd();
    pin_exit("R5 delayed pin wake");

    // R6 reset exit ignores delay bit
    enter_pd();
    rst_exit(RMIN, 1'b0);

    // R7 short reset, then R10 pin wake clears flags
    enter_pd();
    short_rst();
    pin_exit("R5 pin wake after short reset");

    // R8 reset during a long startup
    enter_pd();
    @(negedge clk);
    pd_pin = 1'b1;
    repeat (200) @(negedge clk);
    chk("R8 in startup", state, 2);
    mmap = 1'b1;
    rst_pulse(RMIN + 1);
    measure(n);
    chk("R8 reset cancels count", n, exp_lat(1'b0, 1'b1));
    chk("R8 restart flag", restart_zero, 1);
    chk("R8 boot off with mmap 1", boot_sel, 0);
    pd_pin = 1'b0;

    // R9 events in RUN ignored
    write_ctrl(CADDR, 16'h0000);
    @(negedge clk);
    pd_pin = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 pin in run", state, 0);
    rst_pulse(RMIN + 2);
    repeat (10) @(negedge clk);
    chk("R9 reset in run", state, 0);
    chk("R9 reset in run flag kept", restart_zero, 1);
    enter_pd();
    repeat (20) @(negedge clk);
    chk("R9 pin already high", state, 1);
    idle = 1'b1;
    @(negedge clk);
    idle = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle in powerdown", state, 1);
    pd_pin = 1'b0;
    repeat (5) @(negedge clk);
    pin_exit("R5 pin wake after low");

    // random mix
    for (int it = 0; it < 16; it++) begin
      logic [15:0] d;
      int path;
      d = 16'($urandom);
      if (($urandom % 4) == 0) write_ctrl(14'($urandom) | 14'h0001 & 14'h3FEE, d);
      else                     write_ctrl(CADDR, d);
      enter_pd();
      repeat (1 + ($urandom % 8)) @(negedge clk);
      path = $urandom % 3;
      if (path == 0) begin
        pin_exit("R5 random pin wake");
      end else if (path == 1) begin
        rst_exit(RMIN + ($urandom % 4), 1'($urandom));
      end else begin
        short_rst();
        pin_exit("R5 random pin after short reset");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule